// File: doc/BRIEF.md
# Two-Axis ADC Polling Sequencer

This block sits between a tilt-sensor ADC and a generic SPI master. It configures the master's clock polarity and phase once after reset and then waits in an idle state. A start request makes it read the X-axis channel and then the Y-axis channel, after which it returns to idle. For each channel it loads a 17-bit channel-select command and pulses a send request for one cycle. It then treats the master's busy flag as a two-sided handshake, waiting first for busy to rise and then for busy to fall.

When busy falls, the word the master received during that transfer belongs to the channel that transfer queried. The block slices bits 11 down to 1 out of that word, zero-extends the slice to 16 bits and stores it in that channel's result register. A one-cycle done pulse marks the end of the pair. The serial shifting is done by the master and is not part of this block.

Top module: `tilt_adc_poller`

## Requirements
- R1: While reset is high and in the cycle after it, both results are zero and send and done are low. A synchronous, active-high reset applied mid-transfer abandons the transfer.
- R2: One cycle after reset is released, cpol is 0 and cpha is 1. These values hold until the next reset, and no send occurs before they are set.
- R3: Without a start request the block stays idle and issues no send. A start that is high while a read pair is in progress has no effect.
- R4: Every send is high for exactly one cycle. In that same cycle tx_word holds the command: 17'h1A000 for the X channel and 17'h1E000 for the Y channel.
- R5: After a send, no further send occurs until busy has been seen high and has then been seen low. No send is issued in a cycle that follows a cycle with busy high. Extra cycles with busy low after a send never advance the sequence.
- R6: When busy falls at the end of a transfer, the queried channel's result register takes the value {5'b0, rx_word[11:1]}, with rx_word sampled at that edge. The other channel's register does not change.
- R7: Each start produces exactly two transfers, X first and then Y. The block then returns to idle.
- R8: done is high for exactly one cycle, in the cycle in which the new Y result first appears. done is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one X-then-Y read pair (acted on in idle only) |
| busy | input | 1 | SPI master transfer-in-progress flag |
| rx_word | input | 17 | Word received by the SPI master |
| cpol | output | 1 | SPI clock polarity setting |
| cpha | output | 1 | SPI clock phase setting |
| tx_word | output | 17 | Command word for the SPI master |
| send | output | 1 | One-cycle transfer request |
| x_result | output | 16 | Latest X-axis result |
| y_result | output | 16 | Latest Y-axis result |
| done | output | 1 | One-cycle pulse when the pair completes |

## Verification
The hardest case to reach is the window between a send and the rise of busy. If the sequencer advanced on busy being low there, it would skip a state and mix up the channels. The bench's SPI master model therefore waits a random 1 to 4 cycles before raising busy and holds busy for a random 1 to 6 cycles. Start pulses are also injected during transfers, and one reset is applied in the middle of a transfer to cover abandonment and recovery.

// File: rtl/tilt_adc_poller.sv
module tilt_adc_poller #(
  parameter int CMD_W = 17,
  parameter int RES_W = 16,
  parameter int SLICE_HI = 11,
  parameter int SLICE_LO = 1,
  parameter logic [CMD_W-1:0] CMD_X = 17'h1A000,
  parameter logic [CMD_W-1:0] CMD_Y = 17'h1E000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic [CMD_W-1:0] rx_word,
  output logic             cpol,
  output logic             cpha,
  output logic [CMD_W-1:0] tx_word,
  output logic             send,
  output logic [RES_W-1:0] x_result,
  output logic [RES_W-1:0] y_result,
  output logic             done
);
  localparam int PAD = RES_W - (SLICE_HI - SLICE_LO + 1);

  typedef enum logic [2:0] {
    S_CFG, S_IDLE, S_ISSUE_X, S_ACK_X, S_FIN_X, S_ISSUE_Y, S_ACK_Y, S_FIN_Y
  } seq_t;

  seq_t st;
  logic [RES_W-1:0] decoded;

  assign decoded = {{PAD{1'b0}}, rx_word[SLICE_HI:SLICE_LO]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_CFG;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      tx_word  <= '0;
      send     <= 1'b0;
      done     <= 1'b0;
      x_result <= '0;
      y_result <= '0;
    end else begin
      send <= 1'b0;
      done <= 1'b0;
      case (st)
        S_CFG: begin
          cpol <= 1'b0;
          cpha <= 1'b1;
          st   <= S_IDLE;
        end
        S_IDLE:    if (start) st <= S_ISSUE_X;
        S_ISSUE_X: if (!busy) begin
          tx_word <= CMD_X;
          send    <= 1'b1;
          st      <= S_ACK_X;
        end
        S_ACK_X:   if (busy) st <= S_FIN_X;
        S_FIN_X:   if (!busy) begin
          x_result <= decoded;
          st       <= S_ISSUE_Y;
        end
        S_ISSUE_Y: if (!busy) begin
          tx_word <= CMD_Y;
          send    <= 1'b1;
          st      <= S_ACK_Y;
        end
        S_ACK_Y:   if (busy) st <= S_FIN_Y;
        S_FIN_Y:   if (!busy) begin
          y_result <= decoded;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default:   st <= S_IDLE;
      endcase
    end
  end

  // R4
  send_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    send |=> !send);

  // R5
  no_send_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    send |-> $past(!busy));

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  cfg_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (cpha && !cpol));

  // R6
  y_update_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && !$stable(y_result) |-> done);

endmodule

// File: tb/test_tilt_adc_poller.sv
module test_tilt_adc_poller;
  localparam logic [16:0] CX = 17'h1A000;
  localparam logic [16:0] CY = 17'h1E000;

  logic clk = 0, rst = 1, start = 0, busy = 0;
  logic [16:0] rx_word = '0;
  logic cpol, cpha, send, done;
  logic [16:0] tx_word;
  logic [15:0] x_result, y_result;

  tilt_adc_poller i_tilt_adc_poller (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .rx_word(rx_word),
    .cpol(cpol), .cpha(cpha), .tx_word(tx_word), .send(send),
    .x_result(x_result), .y_result(y_result), .done(done));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
    end
  endtask

  // SPI master model: busy rises after a random latency, is held, then falls
  int ms = 0, mcnt = 0, hold_len = 1;
  always @(posedge clk) begin
    if (rst) begin
      ms <= 0; busy <= 0;
    end else case (ms)
      0: if (send) begin ms <= 1; mcnt <= 1 + $urandom_range(0, 3); hold_len <= 1 + $urandom_range(0, 5); end
      1: if (mcnt <= 1) begin busy <= 1; rx_word <= 17'($urandom); mcnt <= hold_len; ms <= 2; end
         else mcnt <= mcnt - 1;
      default: if (mcnt <= 1) begin busy <= 0; ms <= 0; end else mcnt <= mcnt - 1;
    endcase
  end

  // behavioural reference: phase 0 cfg,1 idle,2 issue,3 wait-high,4 wait-low
  int ph = 0, ch = 0;
  logic m_send = 0, m_done = 0, m_cpha = 0;
  logic [16:0] m_tx = '0;
  logic [15:0] m_x = '0, m_y = '0;
  logic [16:0] sends[$];

  always @(posedge clk) begin
    if (rst) begin
      ph <= 0; m_send <= 0; m_done <= 0; m_cpha <= 0; m_tx <= '0; m_x <= '0; m_y <= '0;
    end else begin
      m_send <= 0; m_done <= 0;
      if (ph == 0) begin m_cpha <= 1; ph <= 1; end
      else if (ph == 1) begin if (start) begin ph <= 2; ch <= 0; end end
      else if (ph == 2) begin
        if (!busy) begin m_send <= 1; m_tx <= ch ? CY : CX; ph <= 3; end
      end else if (ph == 3) begin if (busy) ph <= 4; end
      else if (!busy) begin
        if (ch == 0) begin m_x <= {5'd0, rx_word[11:1]}; ch <= 1; ph <= 2; end
        else begin m_y <= {5'd0, rx_word[11:1]}; m_done <= 1; ph <= 1; end
      end
    end
  end

  // compare on the falling edge
  always @(negedge clk) begin
    chk("R1/R6 x_result", x_result, m_x);
    chk("R1/R6 y_result", y_result, m_y);
    chk("R3/R4/R5 send", send, m_send);
    chk("R8 done", done, m_done);
    chk("R2 cpha", cpha, m_cpha);
    chk("R2 cpol", cpol, 0);
    if (m_send) begin
      chk("R4/R7 tx_word", tx_word, m_tx);
      sends.push_back(tx_word);
    end
    if (done) begin
      // R7: the pair ends with X then Y
      chk("R7 order len", sends.size() >= 2, 1);
      if (sends.size() >= 2) begin
        chk("R7 first X", sends[sends.size()-2], CX);
        chk("R7 then Y", sends[sends.size()-1], CY);
      end
      sends.delete();
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset x", x_result, 0);
    chk("R1 reset send", send, 0);
    rst = 0;
    repeat (8) @(negedge clk);   // R3 idle with no start
    for (int run = 0; run < 30; run++) begin
      start = 1; @(negedge clk); start = 0;
      for (int k = 0; k < 40; k++) begin
        if (k == 5 && run % 3 == 0) begin start = 1; @(negedge clk); start = 0; end // R3 ignored
        else @(negedge clk);
        if (run == 17 && k == 6) begin rst = 1; @(negedge clk); rst = 0; sends.delete(); break; end // R1
        if (done) break;
      end
      repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule